// File: doc/BRIEF.md
# Debug Access Port Address Engine

This block sits behind the register interface of a debug access port. It turns debugger register accesses into single transfers on a memory bus. A debugger configures three things: an access size, an address auto-increment mode and a transfer address.

- Each access to the data window starts one bus transfer at the transfer address.
- Each access to one of four banked windows starts one word transfer at a fixed offset inside the 16-byte block that holds the transfer address. Banked accesses leave that address unchanged.

The engine drives a request to the bus and holds it until the bus reports completion. If auto-increment is enabled, the engine then advances the transfer address. The increment stays inside the current 4 KB window.

Read data returned by the bus is captured in a read-back register for the debugger to collect. A bus error sets a sticky flag instead of advancing the address. A permission input gates every transfer, and its level is visible in the control word.

Top module: `dap_addr_engine`

## Requirements
- R1: After reset the control word reads zero except bit 6 (permission level), the transfer address reads 0, no bus request is active and `reg_ready` is high.
- R2: An accepted access with `reg_sel`=2 starts a transfer in the next cycle. The transfer carries the transfer address, the direction from `reg_wr`, the written data and `bus_size` (00 byte, 01 halfword, 10 word, taken from control bits 2:0). Address, size, direction and data stay constant while `bus_req` is high and `bus_done` is low.
- R3: While a transfer is outstanding `reg_ready` is low, and a register access presented then is ignored.
- R4: On error-free completion of a transfer started from the data window, the transfer address is updated according to the increment mode in control bits 5:4. Mode 00 leaves it unchanged. Modes 01 and 10 add the access size in bytes (1, 2 or 4) to address bits 11:0, wrapping modulo 4096, with bits 31:12 unchanged.
- R5: An access to the data window starts no transfer while the increment mode is 11 or the size field holds a value above 010.
- R6: A transfer completing with `bus_err` high leaves the transfer address unchanged and sets control bit 8. A later write to the control word (`reg_sel`=0) clears bit 8.
- R7: An access with `reg_sel`=4+n (n = 0..3) transfers a word at the transfer address with bits 3:0 replaced by 4*n. It ignores the size and increment fields and never changes the transfer address.
- R8: While `perm_in` is low, data and banked accesses start no transfer. Control bit 6 follows `perm_in`.
- R9: When a read completes without error, `bus_rdata` is captured. From then on it is returned for `reg_sel` 2, 3 and 4 to 7.
- R10: Control bit 7 is high exactly while a transfer is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | Access is a write |
| reg_sel | input | 3 | 0 control, 1 address, 2 data window, 3 read-back, 4-7 banked windows |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the current `reg_sel` |
| reg_ready | output | 1 | Access accepted this cycle when high |
| perm_in | input | 1 | Transfer permission |
| bus_req | output | 1 | Transfer outstanding |
| bus_write | output | 1 | Transfer direction, 1 = write |
| bus_addr | output | 32 | Transfer address |
| bus_size | output | 2 | Transfer size |
| bus_wdata | output | 32 | Transfer write data |
| bus_rdata | input | 32 | Read data, valid with `bus_done` |
| bus_done | input | 1 | Transfer completion |
| bus_err | input | 1 | Error response, valid with `bus_done` |

## Verification
A wrong transfer address becomes visible at the next data access. It shows on `bus_addr` in the cycle after that access is accepted, and immediately on a read of `reg_sel`=1. Wrap and increment faults therefore appear within one transfer of the faulty update.

A stuck or misdecoded busy state shows at `reg_ready` and at bit 7 in the same cycle. A lost error flag or stale read-back data shows on the next read of the control word or the read-back register.

Because the bench compares every port against its model on every clock, a divergence is reported in the cycle it first reaches a port.

// File: rtl/dap_eng_pkg.sv
package dap_eng_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 32;
  localparam int WRAP_BITS = 12;
  localparam int NUM_BANKS = 4;
  localparam int BANK_LSB  = $clog2(NUM_BANKS) + 2;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_ADDR  = 3'd1,
    SEL_DATA  = 3'd2,
    SEL_RDBK  = 3'd3,
    SEL_BANK0 = 3'd4,
    SEL_BANK1 = 3'd5,
    SEL_BANK2 = 3'd6,
    SEL_BANK3 = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    INC_OFF    = 2'b00,
    INC_SINGLE = 2'b01,
    INC_PACKED = 2'b10,
    INC_RSVD   = 2'b11
  } inc_mode_e;

  localparam logic [2:0] SIZE_MAX = 3'b010;
  localparam logic [1:0] BSIZE_WORD = 2'b10;
endpackage

// File: rtl/dap_ctrl_regs.sv
module dap_ctrl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic [2:0] wr_size,
  input  logic [1:0] wr_inc,
  input  logic       err_set,
  output logic [2:0] size_q,
  output logic [1:0] inc_q,
  output logic       err_q
);
  logic [2:0] size_d;
  logic [1:0] inc_d;
  logic       err_d;

  always_comb begin
    size_d = size_q;
    inc_d  = inc_q;
    err_d  = err_q;
    if (wr_ctrl) begin
      size_d = wr_size;
      inc_d  = wr_inc;
      err_d  = 1'b0;
    end else if (err_set) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      inc_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      size_q <= size_d;
      inc_q  <= inc_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/dap_addr_unit.sv
module dap_addr_unit
  import dap_eng_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int WRAPB = WRAP_BITS,
  parameter int NBANK = NUM_BANKS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tar_wr,
  input  logic [AW-1:0]            tar_wdata,
  input  logic                     inc_upd,
  input  logic [1:0]               size_lg,
  input  logic                     bank_acc,
  input  logic [$clog2(NBANK)-1:0] bank_idx,
  output logic [AW-1:0]            tar_q,
  output logic [AW-1:0]            xfer_addr
);
  localparam int IDXW = $clog2(NBANK);
  localparam int BLSB = IDXW + 2;

  logic [AW-1:0]    tar_d;
  logic [WRAPB-1:0] step;
  logic [WRAPB-1:0] low_next;
  logic [AW-1:0]    bank_addr [NBANK];

  assign step     = WRAPB'(1) << size_lg;
  assign low_next = tar_q[WRAPB-1:0] + step;

  genvar g;
  generate
    for (g = 0; g < NBANK; g++) begin : g_bank
      assign bank_addr[g] = {tar_q[AW-1:BLSB], IDXW'(g), 2'b00};
    end
  endgenerate

  assign xfer_addr = bank_acc ? bank_addr[bank_idx] : tar_q;

  always_comb begin
    tar_d = tar_q;
    if (tar_wr) begin
      tar_d = tar_wdata;
    end else if (inc_upd) begin
      tar_d = {tar_q[AW-1:WRAPB], low_next};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tar_q <= '0;
    else        tar_q <= tar_d;
  end
endmodule

// File: rtl/dap_xfer_seq.sv
module dap_xfer_seq
  import dap_eng_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] l_addr,
  input  logic [1:0]    l_size,
  input  logic          l_write,
  input  logic [DW-1:0] l_wdata,
  input  logic          l_bank,
  input  logic          bus_done,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic          bus_write,
  output logic [DW-1:0] bus_wdata,
  output logic          cur_bank,
  output logic          done_ok,
  output logic          done_err,
  output logic [DW-1:0] rb_q
);
  logic          busy_d;
  logic [AW-1:0] addr_d;
  logic [1:0]    size_d;
  logic          write_d;
  logic [DW-1:0] wdata_d;
  logic          bank_d;
  logic [DW-1:0] rb_d;

  assign done_ok  = busy && bus_done && !bus_err;
  assign done_err = busy && bus_done && bus_err;

  always_comb begin
    busy_d  = busy;
    addr_d  = bus_addr;
    size_d  = bus_size;
    write_d = bus_write;
    wdata_d = bus_wdata;
    bank_d  = cur_bank;
    rb_d    = rb_q;
    if (busy) begin
      if (bus_done) busy_d = 1'b0;
      if (done_ok && !bus_write) rb_d = bus_rdata;
    end else if (launch) begin
      busy_d  = 1'b1;
      addr_d  = l_addr;
      size_d  = l_size;
      write_d = l_write;
      wdata_d = l_wdata;
      bank_d  = l_bank;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      bus_addr  <= '0;
      bus_size  <= '0;
      bus_write <= 1'b0;
      bus_wdata <= '0;
      cur_bank  <= 1'b0;
      rb_q      <= '0;
    end else begin
      busy      <= busy_d;
      bus_addr  <= addr_d;
      bus_size  <= size_d;
      bus_write <= write_d;
      bus_wdata <= wdata_d;
      cur_bank  <= bank_d;
      rb_q      <= rb_d;
    end
  end
endmodule

// File: rtl/dap_addr_engine.sv
module dap_addr_engine
  import dap_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_req,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        reg_ready,
  input  logic        perm_in,
  output logic        bus_req,
  output logic        bus_write,
  output logic [31:0] bus_addr,
  output logic [1:0]  bus_size,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_done,
  input  logic        bus_err
);
  logic [1:0]  rst_pipe;
  logic        rst_int_n;
  logic [2:0]  size_q;
  logic [1:0]  inc_q;
  logic        err_q;
  logic [31:0] tar_q;
  logic [31:0] xfer_addr;
  logic [31:0] rb_q;
  logic        busy, cur_bank, done_ok, done_err;
  logic        acc, is_bank, is_data, legal, launch;
  logic        wr_ctrl, wr_tar, inc_upd;
  logic [1:0]  l_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign reg_ready = !busy;
  assign bus_req   = busy;
  assign acc       = reg_req && reg_ready;
  assign is_bank   = reg_sel[2];
  assign is_data   = is_bank || (reg_sel == SEL_DATA);
  assign legal     = is_bank || ((inc_q != INC_RSVD) && (size_q <= SIZE_MAX));
  assign launch    = acc && is_data && perm_in && legal;
  assign wr_ctrl   = acc && reg_wr && (reg_sel == SEL_CTRL);
  assign wr_tar    = acc && reg_wr && (reg_sel == SEL_ADDR);
  assign inc_upd   = done_ok && !cur_bank && (inc_q != INC_OFF);
  assign l_size    = is_bank ? BSIZE_WORD : size_q[1:0];

  dap_ctrl_regs i_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_ctrl (wr_ctrl),
    .wr_size (reg_wdata[2:0]),
    .wr_inc  (reg_wdata[5:4]),
    .err_set (done_err),
    .size_q  (size_q),
    .inc_q   (inc_q),
    .err_q   (err_q)
  );

  dap_addr_unit #(.AW(ADDR_W), .WRAPB(WRAP_BITS), .NBANK(NUM_BANKS)) i_addr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tar_wr    (wr_tar),
    .tar_wdata (reg_wdata),
    .inc_upd   (inc_upd),
    .size_lg   (size_q[1:0]),
    .bank_acc  (is_bank),
    .bank_idx  (reg_sel[1:0]),
    .tar_q     (tar_q),
    .xfer_addr (xfer_addr)
  );

  dap_xfer_seq #(.AW(ADDR_W), .DW(DATA_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .launch    (launch),
    .l_addr    (xfer_addr),
    .l_size    (l_size),
    .l_write   (reg_wr),
    .l_wdata   (reg_wdata),
    .l_bank    (is_bank),
    .bus_done  (bus_done),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .busy      (busy),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_write (bus_write),
    .bus_wdata (bus_wdata),
    .cur_bank  (cur_bank),
    .done_ok   (done_ok),
    .done_err  (done_err),
    .rb_q      (rb_q)
  );

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = {23'd0, err_q, busy, perm_in, inc_q, 1'b0, size_q};
      SEL_ADDR: reg_rdata = tar_q;
      default:  reg_rdata = rb_q;
    endcase
  end
endmodule

// File: rtl/dap_addr_engine_chk.sv
module dap_addr_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_req,
  input logic        reg_ready,
  input logic        perm_in,
  input logic        bus_req,
  input logic        bus_done,
  input logic        bus_err,
  input logic        bus_write,
  input logic [31:0] bus_addr,
  input logic [1:0]  bus_size,
  input logic [31:0] bus_wdata,
  input logic [31:0] tar_q,
  input logic        err_q
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_size)
                                && $stable(bus_write) && $stable(bus_wdata)));

  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !reg_ready);

  assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done && !bus_err) |=> (tar_q[31:12] == $past(tar_q[31:12])));

  assert_errflag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done && bus_err) |=> (err_q && tar_q == $past(tar_q)));

  assert_perm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_ready && !perm_in) |=> !bus_req);

  assert_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_size != 2'b11));
endmodule

bind dap_addr_engine dap_addr_engine_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_req   (reg_req),
  .reg_ready (reg_ready),
  .perm_in   (perm_in),
  .bus_req   (bus_req),
  .bus_done  (bus_done),
  .bus_err   (bus_err),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_size  (bus_size),
  .bus_wdata (bus_wdata),
  .tar_q     (tar_q),
  .err_q     (err_q)
);

// File: tb/test_dap_addr_engine.sv
module test_dap_addr_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_ready, perm_in = 1'b1;
  logic        bus_req, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0]  bus_size;
  logic [31:0] bus_rdata = '0;
  logic        bus_done = 1'b0, bus_err = 1'b0;

  int checks = 0, errors = 0, cycles = 0;
  int resp_lat = 0;
  logic resp_err = 1'b0;
  int wait_cnt = 0;

  always #2.5 clk = ~clk;

  dap_addr_engine i_dap_addr_engine (.*);

  // reference model state
  logic [31:0] m_tar, m_rb, m_addr, m_wdata;
  logic [2:0]  m_size;
  logic [1:0]  m_inc, m_bsize;
  logic        m_err, m_busy, m_write, m_bank;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tar <= 0; m_rb <= 0; m_addr <= 0; m_wdata <= 0; m_size <= 0; m_inc <= 0;
      m_bsize <= 0; m_err <= 0; m_busy <= 0; m_write <= 0; m_bank <= 0;
    end else if (m_busy) begin
      if (bus_done) begin
        m_busy <= 0;
        if (bus_err) m_err <= 1;
        else begin
          if (!m_write) m_rb <= bus_rdata;
          if (!m_bank && m_inc != 0)
            m_tar <= {m_tar[31:12], 12'((m_tar[11:0] + (12'd1 << m_size[1:0])) % 4096)};
        end
      end
    end else if (reg_req) begin
      if (reg_sel == 0 && reg_wr) begin
        m_size <= reg_wdata[2:0]; m_inc <= reg_wdata[5:4]; m_err <= 0;
      end else if (reg_sel == 1 && reg_wr) begin
        m_tar <= reg_wdata;
      end else if (reg_sel == 2 || reg_sel >= 4) begin
        if (perm_in && (reg_sel >= 4 || (m_inc != 3 && m_size <= 2))) begin
          m_busy <= 1; m_write <= reg_wr; m_wdata <= reg_wdata; m_bank <= (reg_sel >= 4);
          if (reg_sel >= 4) begin
            m_addr <= {m_tar[31:4], 4'(4 * (reg_sel - 4))}; m_bsize <= 2;
          end else begin
            m_addr <= m_tar; m_bsize <= m_size[1:0];
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rdata();
    case (reg_sel)
      3'd0: return {23'd0, m_err, m_busy, perm_in, m_inc, 1'b0, m_size};
      3'd1: return m_tar;
      default: return m_rb;
    endcase
  endfunction

  // compare every clock
  always @(negedge clk) begin
    if (rst_n) begin
      check(bus_req == m_busy, "R10 bus_req", 32'(bus_req), 32'(m_busy));
      check(reg_ready == !m_busy, "R3 reg_ready", 32'(reg_ready), 32'(!m_busy));
      check(reg_rdata == exp_rdata(), "R1/R9 reg_rdata", reg_rdata, exp_rdata());
      if (m_busy) begin
        check(bus_addr == m_addr, m_bank ? "R7 bus_addr" : "R2 bus_addr", bus_addr, m_addr);
        check(bus_size == m_bsize, "R2 bus_size", 32'(bus_size), 32'(m_bsize));
        check(bus_write == m_write, "R2 bus_write", 32'(bus_write), 32'(m_write));
        if (m_write) check(bus_wdata == m_wdata, "R2 bus_wdata", bus_wdata, m_wdata);
      end
    end
  end

  // bus responder
  always @(posedge clk) begin
    #1;
    bus_done = 1'b0; bus_err = 1'b0;
    if (bus_req) begin
      if (wait_cnt >= resp_lat) begin
        bus_done = 1'b1; bus_err = resp_err;
        bus_rdata = bus_addr ^ 32'h5A5A_0000;
        wait_cnt = 0;
      end else wait_cnt++;
    end else wait_cnt = 0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", 32'(cycles), 32'd100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic acc(input bit wr, input logic [2:0] sel, input logic [31:0] d);
    @(posedge clk); #1.5;
    while (!reg_ready) begin @(posedge clk); #1.5; end
    reg_req = 1; reg_wr = wr; reg_sel = sel; reg_wdata = d;
    @(posedge clk); #1.5;
    reg_req = 0; reg_wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    while (bus_req) @(posedge clk);
    #1.5;
  endtask

  task automatic peek(input logic [2:0] sel, input logic [31:0] exp, input string req);
    reg_sel = sel; #0.5;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1.5 rst_n = 1;
    repeat (4) @(posedge clk); #1.5;
    peek(0, 32'h0000_0040, "R1 ctrl reset");
    peek(1, 32'h0, "R1 addr reset");
    check(!bus_req && reg_ready, "R1 idle", 32'(bus_req), 0);

    // word single increment with wrap
    acc(1, 1, 32'h1000_1FF8);
    acc(1, 0, 32'h0000_0012);
    acc(1, 2, 32'hAAAA_0001); idle(1);
    peek(1, 32'h1000_1FFC, "R4 word step");
    acc(1, 2, 32'hAAAA_0002); idle(1);
    peek(1, 32'h1000_1000, "R4 wrap 4KB");

    // byte packed increment wrap
    acc(1, 1, 32'h2000_0FFF);
    acc(1, 0, 32'h0000_0020);
    acc(0, 2, 0); idle(1);
    peek(1, 32'h2000_0000, "R4 byte wrap");
    peek(3, 32'h2000_0FFF ^ 32'h5A5A_0000, "R9 readback");

    // halfword, latency 3
    resp_lat = 3;
    acc(1, 0, 32'h0000_0011);
    acc(1, 2, 32'h1234_5678);
    #1; check(bus_req && !reg_ready, "R3 busy stall", 32'(bus_req), 1);
    peek(0, 32'h0000_00D1, "R10 busy bit");
    reg_req = 1; reg_wr = 1; reg_sel = 1; reg_wdata = 32'hDEAD_BEEF;
    @(posedge clk); #1.5; reg_req = 0; reg_wr = 0;
    idle(1);
    peek(1, 32'h2000_0002, "R3 ignored addr write");
    resp_lat = 0;

    // increment off
    acc(1, 0, 32'h0000_0002);
    acc(1, 2, 32'h1); idle(1);
    peek(1, 32'h2000_0002, "R4 no increment");

    // banked
    acc(1, 1, 32'h3000_0124);
    acc(1, 0, 32'h0000_0010);
    acc(0, 6, 0); idle(1);
    peek(1, 32'h3000_0124, "R7 addr kept");
    peek(6, 32'h3000_0128 ^ 32'h5A5A_0000, "R7 bank2 read");
    acc(1, 0, 32'h0000_0030);
    acc(1, 7, 32'hCAFE_0007); idle(1);
    peek(1, 32'h3000_0124, "R7 bank with rsvd inc");

    // reserved inc / size: no transfer
    acc(1, 2, 32'h0BAD_0001); #1;
    check(!bus_req, "R5 rsvd inc", 32'(bus_req), 0);
    acc(1, 0, 32'h0000_0013);
    acc(1, 2, 32'h0BAD_0002); #1;
    check(!bus_req, "R5 rsvd size", 32'(bus_req), 0);
    idle(1);
    peek(1, 32'h3000_0124, "R5 addr kept");

    // error
    acc(1, 0, 32'h0000_0012);
    resp_err = 1;
    acc(1, 2, 32'h0E0E_0E0E); idle(1);
    resp_err = 0;
    peek(0, 32'h0000_0152, "R6 sticky err");
    peek(1, 32'h3000_0124, "R6 addr kept");
    acc(1, 2, 32'h1); idle(1);
    peek(0, 32'h0000_0152, "R6 err stays");
    acc(1, 0, 32'h0000_0012);
    peek(0, 32'h0000_0052, "R6 err cleared");

    // permission low
    perm_in = 0;
    acc(1, 2, 32'h5); #1;
    check(!bus_req, "R8 no xfer", 32'(bus_req), 0);
    acc(0, 4, 0); #1;
    check(!bus_req, "R8 no bank xfer", 32'(bus_req), 0);
    peek(0, 32'h0000_0012, "R8 perm bit");
    perm_in = 1;
    idle(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule